// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Queue

This block is the receive half of an asynchronous serial port. The RX line passes through a two-stage synchronizer and is sampled on a 16x oversampling tick. Characters are assembled in the configured frame format and written into a 16-entry first-in first-out queue. Each character carries four error flags: break, framing, parity and overrun. These flags are stored in a status queue that runs beside the data queue and shares its pointers.

Errors are not reported when a character arrives. They reach the reader only when the affected character is popped. A pop merges that character's flags into a readable status word and, if any flag is set, pulses the error interrupt. A separate status-read strobe clears the word. A receive interrupt pulses for every character written into the queue. A timeout output signals data that has been left in the queue while the line is quiet.

Top module: `uart_rx_efifo`

## Requirements
- R1: A frame is one start bit (0), then 5 to 8 data bits sent LSB first, then an optional parity bit, then 1 or 2 stop bits. `cfg_dbits_i` values 0..3 select 5..8 data bits. The character appears right-aligned on `rd_data_o` with the unused upper bits at zero.
- R2: The queue holds 16 characters in arrival order, and its pointers wrap. `count_o` runs from 0 to 16. A pop while the queue is empty changes nothing.
- R3: A low level on RX is accepted as a start bit only if RX is still low 8 ticks later. A shorter low pulse produces no character.
- R4: A parity mismatch sets status bit 1. With `cfg_par_odd_i`=0 the data bits plus the parity bit must hold an even number of ones; with `cfg_par_odd_i`=1 they must hold an odd number.
- R5: A stop bit sampled as 0 sets status bit 2. The receiver then waits for RX to return high before it looks for a new start.
- R6: A frame that is entirely 0, stop bits included, is stored as character 0 with status bits 3 and 2 set. No further character is taken until RX goes high.
- R7: A character that completes while 16 characters are stored is dropped and the count stays 16. The next character that is stored carries status bit 0.
- R8: `err_stat_o` does not change when a character with errors arrives. When a character is popped, its flags are ORed into `err_stat_o`, and `err_irq_o` pulses for one cycle if any of those flags is set.
- R9: `err_rd_i` clears `err_stat_o`.
- R10: `rx_irq_o` pulses for one cycle for every character written into the queue. It does not pulse for a dropped character.
- R11: `timeout_o` rises once the queue has been non-empty for 3 character times (3 x 16 x frame bits, counted in ticks) with no write and no read. A write, a read or an empty queue clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial input |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| cfg_dbits_i | input | 2 | Data bits minus 5 |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Odd parity when set |
| cfg_stop2_i | input | 1 | Two stop bits when set |
| rd_i | input | 1 | Pop head character |
| err_rd_i | input | 1 | Status read strobe, clears status word |
| rd_data_o | output | 8 | Head character |
| count_o | output | 5 | Characters stored |
| err_stat_o | output | 4 | {break, framing, parity, overrun} of popped characters |
| rx_irq_o | output | 1 | Character written pulse |
| err_irq_o | output | 1 | Popped character had an error |
| timeout_o | output | 1 | Receive timeout |

## Verification
The assertions assume three things about the inputs. The frame configuration is held steady while a character is on the line. `tick_i` comes at 16 per bit time. RX only changes at bit boundaries set by that tick. The bench meets these by tying `tick_i` high, which gives one tick per clock. It holds each bit for exactly 16 clocks and changes the configuration only while the line is idle between frames. Error frames are made by corrupting the parity bit or stop bits of otherwise valid frames, so every expected flag follows from the requirements.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned ERR_W  = 4;
  localparam int unsigned E_OVR  = 0;
  localparam int unsigned E_PAR  = 1;
  localparam int unsigned E_FRM  = 2;
  localparam int unsigned E_BRK  = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_deser.sv
module rx_deser
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic [1:0]        dbits_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o
);
  localparam int unsigned SMP_W = $clog2(OVS);
  localparam int unsigned HALF  = OVS / 2;

  rx_state_e         state_q;
  logic [SMP_W-1:0]  smp_q;
  logic [2:0]        bit_q;
  logic [CHAR_W-1:0] shift_q;
  logic              zero_q, frm_q, par_bit_q, stop_q;
  logic              sample, last_bit, frm_n, brk_n, par_bad;

  assign sample   = tick_i && (smp_q == SMP_W'(OVS - 1));
  assign last_bit = (bit_q == ({1'b0, dbits_i} + 3'd4));
  assign frm_n    = frm_q | ~rx_i;
  assign brk_n    = zero_q & ~rx_i;
  // unused low bits of shift_q stay 0, so the full XOR is the data XOR
  assign par_bad  = par_en_i & (par_bit_q ^ (^shift_q) ^ par_odd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      smp_q     <= '0;
      bit_q     <= '0;
      shift_q   <= '0;
      zero_q    <= 1'b0;
      frm_q     <= 1'b0;
      par_bit_q <= 1'b0;
      stop_q    <= 1'b0;
      valid_o   <= 1'b0;
      data_o    <= '0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      brk_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i && state_q != S_IDLE && state_q != S_HOLD)
        smp_q <= sample ? '0 : smp_q + 1'b1;
      unique case (state_q)
        S_IDLE: if (tick_i && !rx_i) begin
          state_q <= S_START;
          smp_q   <= '0;
        end
        S_START: if (tick_i && smp_q == SMP_W'(HALF - 1)) begin
          if (rx_i) state_q <= S_IDLE;
          else begin
            state_q   <= S_DATA;
            smp_q     <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            zero_q    <= 1'b1;
            frm_q     <= 1'b0;
            par_bit_q <= 1'b0;
            stop_q    <= 1'b0;
          end
        end
        S_DATA: if (sample) begin
          shift_q <= {rx_i, shift_q[CHAR_W-1:1]};
          zero_q  <= zero_q & ~rx_i;
          bit_q   <= bit_q + 1'b1;
          if (last_bit) state_q <= par_en_i ? S_PAR : S_STOP;
        end
        S_PAR: if (sample) begin
          par_bit_q <= rx_i;
          zero_q    <= zero_q & ~rx_i;
          state_q   <= S_STOP;
        end
        S_STOP: if (sample) begin
          if (stop2_i && !stop_q) begin
            stop_q <= 1'b1;
            frm_q  <= frm_n;
            zero_q <= brk_n;
          end else begin
            valid_o   <= 1'b1;
            data_o    <= shift_q >> (2'd3 - dbits_i);
            par_err_o <= par_bad;
            frm_err_o <= frm_n;
            brk_o     <= brk_n;
            state_q   <= (frm_n || !rx_i) ? S_HOLD : S_IDLE;
          end
        end
        S_HOLD: if (rx_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10: one character event per frame
  a_r10_single_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6: a break always carries a framing error
  a_r6_brk_has_frm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && brk_o |-> frm_err_o && data_o == '0);
  // R3: a character is only emitted after a confirmed start
  a_r3_valid_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(state_q) == S_STOP);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAT_W = 4,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [DATA_W-1:0]        pdata_i,
  input  logic [STAT_W-1:0]        pstat_i,
  input  logic                     pop_i,
  output logic [DATA_W-1:0]        hdata_o,
  output logic [STAT_W-1:0]        hstat_o,
  output logic [$clog2(DEPTH):0]   count_o,
  output logic                     full_o,
  output logic                     empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [DATA_W-1:0] dmem [DEPTH];
  logic [STAT_W-1:0] smem [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) begin
      dmem[wr_q] <= pdata_i;
      smem[wr_q] <= pstat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign hdata_o = dmem[rd_q];
  assign hstat_o = smem[rd_q];
  assign count_o = cnt_q;

  a_r2_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r2_empty_pop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i |=> $stable(cnt_q) && $stable(rd_q));
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
  parameter int unsigned OVS  = 16,
  parameter int unsigned TO_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       nonempty_i,
  input  logic [3:0] frame_bits_i,
  output logic       timeout_o
);
  localparam int unsigned CHARS = 3;

  logic [TO_W-1:0] cnt_q, limit;

  assign limit = TO_W'(CHARS * OVS) * {{(TO_W-4){1'b0}}, frame_bits_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                           cnt_q <= '0;
    else if (push_i || pop_i || !nonempty_i) cnt_q <= '0;
    else if (tick_i && cnt_q < limit)        cnt_q <= cnt_q + 1'b1;

  assign timeout_o = nonempty_i && (cnt_q >= limit);
endmodule

// File: rtl/uart_rx_efifo.sv
module uart_rx_efifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OVS   = 16,
  parameter int unsigned TO_W  = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rx_i,
  input  logic                   tick_i,
  input  logic [1:0]             cfg_dbits_i,
  input  logic                   cfg_par_en_i,
  input  logic                   cfg_par_odd_i,
  input  logic                   cfg_stop2_i,
  input  logic                   rd_i,
  input  logic                   err_rd_i,
  output logic [7:0]             rd_data_o,
  output logic [$clog2(DEPTH):0] count_o,
  output logic [3:0]             err_stat_o,
  output logic                   rx_irq_o,
  output logic                   err_irq_o,
  output logic                   timeout_o
);
  logic              rx_s, ch_valid, ch_par, ch_frm, ch_brk;
  logic [CHAR_W-1:0] ch_data;
  logic              full, empty, push, pop_ok, ovr_pend_q;
  logic [ERR_W-1:0]  push_stat, head_stat, err_stat_q;
  logic              rx_irq_q, err_irq_q;
  logic [3:0]        frame_bits;

  rx_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s));

  rx_deser #(.OVS(OVS)) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_s), .tick_i(tick_i),
    .dbits_i(cfg_dbits_i), .par_en_i(cfg_par_en_i), .par_odd_i(cfg_par_odd_i),
    .stop2_i(cfg_stop2_i), .valid_o(ch_valid), .data_o(ch_data),
    .par_err_o(ch_par), .frm_err_o(ch_frm), .brk_o(ch_brk));

  assign push   = ch_valid && !full;
  assign pop_ok = rd_i && !empty;

  always_comb begin
    push_stat        = '0;
    push_stat[E_OVR] = ovr_pend_q;
    push_stat[E_PAR] = ch_par;
    push_stat[E_FRM] = ch_frm;
    push_stat[E_BRK] = ch_brk;
  end

  rx_fifo #(.DATA_W(CHAR_W), .STAT_W(ERR_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pdata_i(ch_data),
    .pstat_i(push_stat), .pop_i(rd_i), .hdata_o(rd_data_o),
    .hstat_o(head_stat), .count_o(count_o), .full_o(full), .empty_o(empty));

  assign frame_bits = 4'd7 + {2'b00, cfg_dbits_i} + {3'b000, cfg_par_en_i}
                    + {3'b000, cfg_stop2_i};

  rx_timeout #(.OVS(OVS), .TO_W(TO_W)) u_to (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .push_i(push),
    .pop_i(pop_ok), .nonempty_i(!empty), .frame_bits_i(frame_bits),
    .timeout_o(timeout_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_pend_q <= 1'b0;
      err_stat_q <= '0;
      rx_irq_q   <= 1'b0;
      err_irq_q  <= 1'b0;
    end else begin
      if (ch_valid && full) ovr_pend_q <= 1'b1;
      else if (push)        ovr_pend_q <= 1'b0;
      rx_irq_q  <= push;
      err_irq_q <= pop_ok && (|head_stat);
      if (pop_ok)        err_stat_q <= (err_rd_i ? '0 : err_stat_q) | head_stat;
      else if (err_rd_i) err_stat_q <= '0;
    end
  end

  assign err_stat_o = err_stat_q;
  assign rx_irq_o   = rx_irq_q;
  assign err_irq_o  = err_irq_q;

  // R7: a dropped character leaves a pending overrun tag
  a_r7_drop_tags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_valid && full |=> ovr_pend_q);
  // R8: status only grows on a pop
  a_r8_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_stat_q & ~$past(err_stat_q)) != '0 |-> $past(pop_ok));
  a_r8_irq_on_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> $past(rd_i) && |err_stat_o);
  // R10: pulse follows a write into a non-full queue
  a_r10_irq_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> count_o != '0);
  // R11: timeout never rises in a cycle after a write or read
  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !$past(push) && !$past(pop_ok));
endmodule

// File: tb/tb_uart_rx_efifo.sv
module tb_uart_rx_efifo;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b1;
  logic [1:0] dbits = 2'd3;
  logic pe = 1'b0, po = 1'b0, s2 = 1'b0, rd = 1'b0, err_rd = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic [3:0] err_stat;
  logic rx_irq, err_irq, timeout;
  int n_chk = 0, n_bad = 0, irq_n = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_rx_efifo dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick),
    .cfg_dbits_i(dbits), .cfg_par_en_i(pe), .cfg_par_odd_i(po),
    .cfg_stop2_i(s2), .rd_i(rd), .err_rd_i(err_rd), .rd_data_o(rd_data),
    .count_o(count), .err_stat_o(err_stat), .rx_irq_o(rx_irq),
    .err_irq_o(err_irq), .timeout_o(timeout));

  always @(posedge clk) if (rx_irq) irq_n++;

  // {dbits, par_en, par_odd, stop2, bad_par, bad_stop, data, exp_err}
  localparam logic [18:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 4'h0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 4'h0},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5B, 4'h0},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 4'h0},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 4'h2},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2A, 4'h2},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h7E, 4'h4},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h15, 4'h4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bp, input logic bs);
    int nb;
    logic [7:0] m;
    logic p;
    nb = 5 + int'(dbits);
    m  = 8'hFF >> (8 - nb);
    p  = (^(d & m)) ^ po ^ bp;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (pe) send_bit(p);
    send_bit(!bs);
    if (s2) send_bit(!bs);
    send_bit(1'b1);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp_d, input logic [3:0] exp_e);
    chk(req, rd_data, exp_d);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk(req, err_stat, exp_e);
    chk(req, err_irq, |exp_e);
    err_rd = 1'b1; @(negedge clk); err_rd = 1'b0;
    chk("R9", err_stat, 4'h0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("reset count", count, 0);
    chk("reset stat", err_stat, 0);
    chk("reset irq", rx_irq, 0);
    chk("reset R11", timeout, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: pop on empty queue has no effect
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R2 empty pop count", count, 0);
    chk("R2 empty pop stat", err_stat, 0);

    // R1 R4 R5 R8 vector walk
    for (int v = 0; v < 8; v++) begin
      logic [7:0] m;
      dbits = VEC[v][18:17]; pe = VEC[v][16]; po = VEC[v][15]; s2 = VEC[v][14];
      base = irq_n;
      send_frame(VEC[v][11:4], VEC[v][13], VEC[v][12]);
      m = 8'hFF >> (3 - int'(dbits));
      chk("R10 one pulse", irq_n - base, 1);
      chk("R1 count", count, 1);
      chk("R8 no early status", err_stat, 0);
      pop_chk("R1 R4 R5 vector", VEC[v][11:4] & m, VEC[v][3:0]);
    end

    // R3: short low glitch
    dbits = 2'd3; pe = 1'b0; po = 1'b0; s2 = 1'b0;
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (200) @(negedge clk);
    chk("R3 glitch ignored", count, 0);

    // R6: line held low for three frame times
    base = irq_n;
    rx = 1'b0; repeat (480) @(negedge clk);
    rx = 1'b1; repeat (40) @(negedge clk);
    chk("R6 single char", count, 1);
    chk("R6 single pulse", irq_n - base, 1);
    pop_chk("R6 break", 8'h00, 4'hC);

    // R7 R2 R10: overflow by one
    base = irq_n;
    for (int i = 0; i < 17; i++) send_frame(8'h10 + 8'(i), 1'b0, 1'b0);
    chk("R2 full count", count, 16);
    chk("R10 dropped no pulse", irq_n - base, 16);
    for (int i = 0; i < 16; i++) pop_chk("R2 order", 8'h10 + 8'(i), 4'h0);
    send_frame(8'h5A, 1'b0, 1'b0);
    pop_chk("R7 overrun tag", 8'h5A, 4'h1);

    // R11: timeout
    send_frame(8'hC3, 1'b0, 1'b0);
    chk("R11 not yet", timeout, 0);
    repeat (500) @(negedge clk);
    chk("R11 raised", timeout, 1);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R11 cleared", timeout, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule